// File: doc/BRIEF.md
# Packed Transmit/Receive Byte FIFO Pair

This block sits between a processor register port and a serial shifter. It holds two independent byte-wide FIFOs of four bytes each by default: one carries data from the register port towards the shifter, the other carries received frames back to the register port. The register port moves either one byte or two bytes per access. Frames of eight bits or fewer occupy one byte each, so a single 16-bit access moves two such frames, the earlier frame in the low byte. Frames wider than eight bits occupy two bytes, low byte first.

Three flags are produced. The transmit-space flag stays high while at least two bytes are free, so that any following access fits. Because of this rule a byte write that leaves exactly one byte free already drops the flag. The receive flag rises when the receive FIFO holds at least one byte, or at least two bytes when the half-word threshold is selected. Each flag is also driven out as a DMA request for its direction.

The shifter side of the transmit FIFO is a valid/ready stream: the FIFO offers a frame while it holds enough bytes for one frame, and the frame leaves on a cycle where valid and ready are both high. The shifter may hold ready low for as long as it likes. The receive side has no ready signal, because a serial receiver cannot pause. A frame that does not fit is dropped, and a sticky overrun flag is set instead.

Top module: `spi_pack_fifo`

## Requirements
- R1: After reset both FIFOs are empty: tx_empty is 1, rx_not_empty is 0, rx_overrun is 0 and tx_frame_valid is 0.
- R2: A byte write (reg_wr_wide=0) appends reg_wr_data[7:0] to the transmit FIFO when at least one byte is free; otherwise it is ignored.
- R3: A half-word write (reg_wr_wide=1) appends reg_wr_data[7:0] and then reg_wr_data[15:8] when at least two bytes are free; otherwise neither byte is stored.
- R4: tx_empty is 1 exactly when at least two transmit bytes are free, so it is 0 with three of four bytes used. It is 1 on the cycle after tx_flush.
- R5: With frame_wide=0, tx_frame_valid is 1 when one or more bytes are held, and tx_frame_data is {8'h00, oldest byte}. With frame_wide=1, it needs two bytes and the data is {second byte, oldest byte}. A frame is removed when valid and ready are both 1.
- R6: A receive frame (rx_frame_valid=1) stores one byte (frame_wide=0, rx_frame_data[7:0]) or two bytes (frame_wide=1, low byte first) when they fit. Otherwise the frame is dropped, the FIFO is unchanged and rx_overrun becomes 1 and stays 1 until rx_flush.
- R7: A byte read (reg_rd_en=1, reg_rd_wide=0) returns {8'h00, oldest byte} and removes it. On an empty FIFO it returns zero and changes nothing.
- R8: A half-word read with two or more bytes returns {second, oldest} and removes two. With one byte it returns {8'h00, byte} and removes one. With none it returns zero.
- R9: rx_not_empty is 1 when the receive FIFO holds at least one byte (rx_thr_half=0) or at least two bytes (rx_thr_half=1).
- R10: tx_dma_req equals tx_empty and rx_dma_req equals rx_not_empty on every cycle.
- R11: rx_flush empties the receive FIFO and clears rx_overrun without touching the transmit FIFO. tx_flush empties the transmit FIFO without touching the receive FIFO. A flush overrides every other operation on its FIFO in that cycle.
- R12: Room and data checks use the occupancy at the start of the cycle. A write into a full transmit FIFO is dropped even if a frame leaves in the same cycle, and a receive frame arriving at a full FIFO overruns even if a read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wide | input | 1 | 1: frames longer than 8 bits (two bytes each) |
| rx_thr_half | input | 1 | 1: receive flag needs two bytes |
| tx_flush | input | 1 | Empty the transmit FIFO |
| rx_flush | input | 1 | Empty the receive FIFO, clear overrun |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_wide | input | 1 | 1: half-word write, 0: byte write |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_wide | input | 1 | 1: half-word read, 0: byte read |
| reg_rd_data | output | 16 | Register read data, valid while reg_rd_en is high |
| tx_frame_valid | output | 1 | A transmit frame is available |
| tx_frame_ready | input | 1 | Shifter takes the frame |
| tx_frame_data | output | 16 | Transmit frame |
| rx_frame_valid | input | 1 | Received frame strobe |
| rx_frame_data | input | 16 | Received frame |
| tx_empty | output | 1 | Room for any next access |
| rx_not_empty | output | 1 | Receive threshold reached |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with its default depth of four bytes. With so little storage, every occupancy from empty to full can be reached within a handful of accesses. This includes the three-byte state in which the transmit flag has already dropped, and the single-byte state where a half-word read returns only half its data. Both read and write pointers also wrap many times during the long mixed run. Overrun at a full FIFO, and same-cycle push/pop at the full and empty edges, therefore come up in both the directed and the mixed stimulus.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  // number of bytes moved into or out of a FIFO in one cycle
  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_ONE  = 2'd1,
    MOVE_TWO  = 2'd2
  } move_t;
endpackage

// File: rtl/pkf_byte_ring.sv
module pkf_byte_ring
  import pkf_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  move_t             push_n,
  input  logic [WORD_W-1:0] push_data,
  input  move_t             pop_n,
  output logic [CNT_W-1:0]  level,
  output logic [WORD_W-1:0] peek
);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [PTR_W-1:0]  wp1, wp2, rp1, rp2;

  assign wp1 = nxt(wp);
  assign wp2 = nxt(wp1);
  assign rp1 = nxt(rp);
  assign rp2 = nxt(rp1);

  // storage: the caller only issues pushes that fit
  always_ff @(posedge clk) begin
    if (push_n != MOVE_NONE) mem[wp]  <= push_data[BYTE_W-1:0];
    if (push_n == MOVE_TWO)  mem[wp1] <= push_data[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      unique case (push_n)
        MOVE_ONE: wp <= wp1;
        MOVE_TWO: wp <= wp2;
        default:  wp <= wp;
      endcase
      unique case (pop_n)
        MOVE_ONE: rp <= rp1;
        MOVE_TWO: rp <= rp2;
        default:  rp <= rp;
      endcase
      level <= level + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  assign peek = {mem[rp1], mem[rp]};

endmodule

// File: rtl/pkf_tx_ctrl.sv
module pkf_tx_ctrl
  import pkf_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              flush,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic              frame_wide,
  input  logic              frame_ready,
  input  logic [CNT_W-1:0]  level,
  input  logic [WORD_W-1:0] peek,
  output move_t             push_n,
  output move_t             pop_n,
  output logic              frame_valid,
  output logic [WORD_W-1:0] frame_data,
  output logic              room_flag
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_b;
  logic             wr_fits;

  always_comb begin
    free_b  = CAP - level;
    wr_fits = wr_wide ? (free_b >= CNT_W'(2)) : (free_b >= CNT_W'(1));

    if (flush || !wr_en || !wr_fits) push_n = MOVE_NONE;
    else if (wr_wide)                push_n = MOVE_TWO;
    else                             push_n = MOVE_ONE;

    frame_valid = frame_wide ? (level >= CNT_W'(2)) : (level >= CNT_W'(1));
    frame_data  = frame_wide ? peek : {{BYTE_W{1'b0}}, peek[BYTE_W-1:0]};

    if (flush || !(frame_valid && frame_ready)) pop_n = MOVE_NONE;
    else if (frame_wide)                        pop_n = MOVE_TWO;
    else                                        pop_n = MOVE_ONE;

    // room for the widest access, so a byte write into the
    // second-to-last slot already drops the flag
    room_flag = free_b >= CNT_W'(2);
  end

endmodule

// File: rtl/pkf_rx_ctrl.sv
module pkf_rx_ctrl
  import pkf_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              frame_wide,
  input  logic              thr_half,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rd_en,
  input  logic              rd_wide,
  input  logic [CNT_W-1:0]  level,
  input  logic [WORD_W-1:0] peek,
  output move_t             push_n,
  output logic [WORD_W-1:0] push_data,
  output move_t             pop_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              avail_flag,
  output logic              overrun
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_b;
  logic             fits, has1, has2, drop;

  always_comb begin
    free_b = CAP - level;
    fits   = frame_wide ? (free_b >= CNT_W'(2)) : (free_b >= CNT_W'(1));
    has1   = level >= CNT_W'(1);
    has2   = level >= CNT_W'(2);
    drop   = in_valid && !fits;

    if (flush || !in_valid || !fits) push_n = MOVE_NONE;
    else if (frame_wide)             push_n = MOVE_TWO;
    else                             push_n = MOVE_ONE;
    push_data = frame_wide ? in_data : {{BYTE_W{1'b0}}, in_data[BYTE_W-1:0]};

    if (flush || !rd_en || !has1) pop_n = MOVE_NONE;
    else if (rd_wide && has2)     pop_n = MOVE_TWO;
    else                          pop_n = MOVE_ONE;

    rd_data[BYTE_W-1:0]      = has1 ? peek[BYTE_W-1:0] : '0;
    rd_data[WORD_W-1:BYTE_W] = (rd_wide && has2) ? peek[WORD_W-1:BYTE_W] : '0;

    avail_flag = thr_half ? has2 : has1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     overrun <= 1'b0;
    else if (flush) overrun <= 1'b0;
    else if (drop)  overrun <= 1'b1;
  end

endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo
  import pkf_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_wide,
  input  logic        rx_thr_half,
  input  logic        tx_flush,
  input  logic        rx_flush,
  input  logic        reg_wr_en,
  input  logic        reg_wr_wide,
  input  logic [15:0] reg_wr_data,
  input  logic        reg_rd_en,
  input  logic        reg_rd_wide,
  output logic [15:0] reg_rd_data,
  output logic        tx_frame_valid,
  input  logic        tx_frame_ready,
  output logic [15:0] tx_frame_data,
  input  logic        rx_frame_valid,
  input  logic [15:0] rx_frame_data,
  output logic        tx_empty,
  output logic        rx_not_empty,
  output logic        tx_dma_req,
  output logic        rx_dma_req,
  output logic        rx_overrun
);

  localparam int unsigned CNT_W = $clog2(DEPTH_BYTES + 1);

  move_t             tx_push, tx_pop, rx_push, rx_pop;
  logic [CNT_W-1:0]  tx_level, rx_level;
  logic [WORD_W-1:0] tx_peek, rx_peek, rx_wdata;

  pkf_byte_ring #(.DEPTH(DEPTH_BYTES)) i_tx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push_n    (tx_push),
    .push_data (reg_wr_data),
    .pop_n     (tx_pop),
    .level     (tx_level),
    .peek      (tx_peek)
  );

  pkf_tx_ctrl #(.DEPTH(DEPTH_BYTES)) i_tx_ctrl (
    .flush       (tx_flush),
    .wr_en       (reg_wr_en),
    .wr_wide     (reg_wr_wide),
    .frame_wide  (frame_wide),
    .frame_ready (tx_frame_ready),
    .level       (tx_level),
    .peek        (tx_peek),
    .push_n      (tx_push),
    .pop_n       (tx_pop),
    .frame_valid (tx_frame_valid),
    .frame_data  (tx_frame_data),
    .room_flag   (tx_empty)
  );

  pkf_byte_ring #(.DEPTH(DEPTH_BYTES)) i_rx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push_n    (rx_push),
    .push_data (rx_wdata),
    .pop_n     (rx_pop),
    .level     (rx_level),
    .peek      (rx_peek)
  );

  pkf_rx_ctrl #(.DEPTH(DEPTH_BYTES)) i_rx_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (rx_flush),
    .frame_wide (frame_wide),
    .thr_half   (rx_thr_half),
    .in_valid   (rx_frame_valid),
    .in_data    (rx_frame_data),
    .rd_en      (reg_rd_en),
    .rd_wide    (reg_rd_wide),
    .level      (rx_level),
    .peek       (rx_peek),
    .push_n     (rx_push),
    .push_data  (rx_wdata),
    .pop_n      (rx_pop),
    .rd_data    (reg_rd_data),
    .avail_flag (rx_not_empty),
    .overrun    (rx_overrun)
  );

  // DMA requests follow the threshold events of each direction
  assign tx_dma_req = tx_empty;
  assign rx_dma_req = rx_not_empty;

endmodule

// File: rtl/pkf_checker.sv
module pkf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_wide,
  input logic        rx_thr_half,
  input logic        tx_flush,
  input logic        rx_flush,
  input logic        reg_rd_en,
  input logic [15:0] reg_rd_data,
  input logic        tx_frame_valid,
  input logic [15:0] tx_frame_data,
  input logic        tx_empty,
  input logic        rx_not_empty,
  input logic        rx_overrun
);

  // R4: a transmit flush leaves full room and nothing to send
  a_r4_flush_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_empty && !tx_frame_valid));

  // R5: narrow frames carry zero in the upper byte
  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_valid && !frame_wide) |-> (tx_frame_data[15:8] == 8'h00));

  // R6: overrun is sticky until a receive flush
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_flush) |=> rx_overrun);

  // R7: reading an empty receive FIFO yields zero
  a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !rx_thr_half && !rx_not_empty) |-> (reg_rd_data == 16'h0000));

  // R11: a receive flush empties the FIFO and clears overrun
  a_r11_rx_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (!rx_overrun && !rx_not_empty));

endmodule

bind spi_pack_fifo pkf_checker i_pkf_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_wide     (frame_wide),
  .rx_thr_half    (rx_thr_half),
  .tx_flush       (tx_flush),
  .rx_flush       (rx_flush),
  .reg_rd_en      (reg_rd_en),
  .reg_rd_data    (reg_rd_data),
  .tx_frame_valid (tx_frame_valid),
  .tx_frame_data  (tx_frame_data),
  .tx_empty       (tx_empty),
  .rx_not_empty   (rx_not_empty),
  .rx_overrun     (rx_overrun)
);

// File: tb/test_spi_pack_fifo.sv
module test_spi_pack_fifo;

  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_wide = 1'b0, rx_thr_half = 1'b0;
  logic        tx_flush = 1'b0, rx_flush = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_wide = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0, reg_rd_wide = 1'b0;
  logic [15:0] reg_rd_data;
  logic        tx_frame_valid, tx_frame_ready = 1'b0;
  logic [15:0] tx_frame_data;
  logic        rx_frame_valid = 1'b0;
  logic [15:0] rx_frame_data = '0;
  logic        tx_empty, rx_not_empty, tx_dma_req, rx_dma_req, rx_overrun;

  always #4 clk = ~clk;

  spi_pack_fifo #(.DEPTH_BYTES(D)) i_spi_pack_fifo (.*);

  int n_checks = 0, n_fail = 0;
  string phase = "INIT";

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit         ovr = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, what, act, exp);
    end
  endtask

  // check outputs against the model, then advance the model over one edge
  task automatic cyc();
    int tl, rl, npop;
    logic ev;
    #1;
    tl = txq.size();
    rl = rxq.size();
    check("R4", "tx_empty", 16'(tx_empty), 16'((D - tl) >= 2));
    check("R10", "tx_dma_req", 16'(tx_dma_req), 16'((D - tl) >= 2));
    ev = frame_wide ? (tl >= 2) : (tl >= 1);
    check("R5", "tx_frame_valid", 16'(tx_frame_valid), 16'(ev));
    if (ev)
      check("R5", "tx_frame_data", tx_frame_data,
            frame_wide ? {txq[1], txq[0]} : {8'h00, txq[0]});
    check("R9", "rx_not_empty", 16'(rx_not_empty), 16'(rx_thr_half ? (rl >= 2) : (rl >= 1)));
    check("R10", "rx_dma_req", 16'(rx_dma_req), 16'(rx_thr_half ? (rl >= 2) : (rl >= 1)));
    check("R6", "rx_overrun", 16'(rx_overrun), 16'(ovr));
    if (reg_rd_en) begin
      logic [15:0] er;
      er[7:0]  = (rl >= 1) ? rxq[0] : 8'h00;
      er[15:8] = (reg_rd_wide && rl >= 2) ? rxq[1] : 8'h00;
      check(reg_rd_wide ? "R8" : "R7", "reg_rd_data", reg_rd_data, er);
    end
    // transmit side
    if (tx_flush) txq.delete();
    else begin
      npop = (tx_frame_ready && ev) ? (frame_wide ? 2 : 1) : 0;
      if (reg_wr_en) begin
        if (reg_wr_wide && (D - tl) >= 2) begin
          txq.push_back(reg_wr_data[7:0]);
          txq.push_back(reg_wr_data[15:8]);
        end else if (!reg_wr_wide && (D - tl) >= 1)
          txq.push_back(reg_wr_data[7:0]);
      end
      repeat (npop) void'(txq.pop_front());
    end
    // receive side
    if (rx_flush) begin
      rxq.delete();
      ovr = 1'b0;
    end else begin
      npop = !reg_rd_en ? 0 : (reg_rd_wide && rl >= 2) ? 2 : (rl >= 1) ? 1 : 0;
      if (rx_frame_valid) begin
        if ((D - rl) >= (frame_wide ? 2 : 1)) begin
          rxq.push_back(rx_frame_data[7:0]);
          if (frame_wide) rxq.push_back(rx_frame_data[15:8]);
        end else ovr = 1'b1;
      end
      repeat (npop) void'(rxq.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    reg_wr_en = 0; reg_rd_en = 0; rx_frame_valid = 0;
    tx_frame_ready = 0; tx_flush = 0; rx_flush = 0;
  endtask

  task automatic wr(input bit wide, input logic [15:0] d);
    reg_wr_en = 1; reg_wr_wide = wide; reg_wr_data = d; cyc();
  endtask
  task automatic rd(input bit wide);
    reg_rd_en = 1; reg_rd_wide = wide; cyc();
  endtask
  task automatic rxp(input logic [15:0] d);
    rx_frame_valid = 1; rx_frame_data = d; cyc();
  endtask
  task automatic pull();
    tx_frame_ready = 1; cyc();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    phase = "R1";
    check("R1", "tx_empty", 16'(tx_empty), 16'h1);
    check("R1", "rx_not_empty", 16'(rx_not_empty), 16'h0);
    check("R1", "rx_overrun", 16'(rx_overrun), 16'h0);
    check("R1", "tx_frame_valid", 16'(tx_frame_valid), 16'h0);

    phase = "R2";   // byte writes up to full, one extra dropped
    wr(0, 16'h00A1); wr(0, 16'h00A2); wr(0, 16'h00A3); wr(0, 16'h00A4); wr(0, 16'h00A5);
    repeat (5) pull();

    phase = "R3";   // half-word write, then one that does not fit
    wr(1, 16'hB2B1); wr(0, 16'h00B3); wr(1, 16'hB5B4);
    frame_wide = 1;
    phase = "R5";
    pull(); pull(); pull();      // one wide frame, then one byte cannot form a frame
    frame_wide = 0;
    pull();

    phase = "R6";   // narrow receive up to overrun
    rxp(16'h00C1); rxp(16'h00C2); rxp(16'h00C3); rxp(16'h00C4); rxp(16'h00C5);
    phase = "R8";
    rd(1); rd(0);
    rx_thr_half = 1;
    phase = "R9";
    cyc();
    rx_thr_half = 0;
    cyc();
    phase = "R8";
    rd(1); rd(1);
    phase = "R7";
    rd(0);
    frame_wide = 1;
    phase = "R6";
    rxp(16'hD2D1); rxp(16'hD4D3); rxp(16'hD6D5);
    frame_wide = 0;

    phase = "R11";  // independent flushes
    wr(1, 16'hE2E1);
    rx_flush = 1; cyc();
    pull();
    rxp(16'h00E7);
    tx_flush = 1; cyc();
    rd(0);

    phase = "R12";  // same-cycle push and pop at the full edges
    wr(1, 16'hF2F1); wr(1, 16'hF4F3);
    reg_wr_en = 1; reg_wr_wide = 0; reg_wr_data = 16'h00F5; tx_frame_ready = 1; cyc();
    pull(); pull(); pull(); pull();
    rxp(16'h0011); rxp(16'h0022); rxp(16'h0033); rxp(16'h0044);
    rx_frame_valid = 1; rx_frame_data = 16'h0055; reg_rd_en = 1; reg_rd_wide = 0; cyc();
    rx_flush = 1; cyc();

    phase = "MIX";
    for (int i = 0; i < 4000; i++) begin
      if ((i % 97) == 0) begin
        frame_wide  = $urandom_range(0, 1);
        rx_thr_half = $urandom_range(0, 1);
      end
      reg_wr_en      = ($urandom_range(0, 2) == 0);
      reg_wr_wide    = $urandom_range(0, 1);
      reg_wr_data    = 16'($urandom);
      reg_rd_en      = ($urandom_range(0, 2) == 0);
      reg_rd_wide    = $urandom_range(0, 1);
      rx_frame_valid = ($urandom_range(0, 2) == 0);
      rx_frame_data  = 16'($urandom);
      tx_frame_ready = ($urandom_range(0, 1) == 0);
      tx_flush       = ($urandom_range(0, 60) == 0);
      rx_flush       = ($urandom_range(0, 60) == 0);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule